// File: doc/BRIEF.md
# Restartable Control-Image Register Loader

This block copies a block of 32-bit control-image words from memory into a circular bank of write-lock registers. It moves one word per step. A caller pulses `start` with an image pointer, a word count, a first register index and a lock-mode flag. The sequencer then issues one read per word, writes each clean word into the next register and advances its pointer, remaining count and register index. When the count reaches zero it raises `done` for one cycle.

The loader can be suspended after any word. If `irq` is high when a word's response arrives and more words remain, the loader writes that word and stops with `paused`. At that point `cur_ptr`, `cur_cnt` and `cur_idx` describe the next word, and a later `start` with those values finishes the job.

A bad read ends the run with `trap` and no register write. A fault response means a missing or protected page. A parity error additionally reports `trap_parity` and `reg_altered`. In both cases the saved state keeps its value from before the failed word.

The read request is a valid/ready stream. `rd_valid` stays high with a stable `rd_addr` until `rd_ready` accepts it. Only one read is outstanding at a time, and its response is taken on any cycle in which `rsp_valid` is high while the loader waits. No response is expected at any other time.

Top module: `imglock_loader`

## Requirements
- R1: After reset, `busy`, `done`, `paused`, `trap`, `trap_parity`, `reg_altered`, `rd_valid` and `wr_en` are all 0.
- R2: The k-th word of a run is read from `start_ptr+k` and written to register index `start_idx+k` (wrapped), with `wr_data` equal to the returned word.
- R3: When a run completes, `done` is high for exactly one cycle. At that point `cur_ptr` = start pointer + start count, `cur_cnt` = 0 and `cur_idx` = (start index + start count) modulo the bank size.
- R4: With `mode2`=1 the bank has 2^IW registers and index 2^IW-1 is followed by 0. A count above that size overwrites the first registers. With `mode2`=0 the bank has 2^(IW-1) registers, the index top bit is always 0 (also for the start index), and index 2^(IW-1)-1 is followed by 0.
- R5: A start with count 0 raises `done` in the cycle after the start edge. It issues no read and no write.
- R6: While `rd_valid` is high and `rd_ready` is low, `rd_valid` stays high and `rd_addr` stays stable in the next cycle.
- R7: Suppose `irq` is high in the cycle a clean response is accepted, and words remain after it. Then that word is written, `paused` is high for one cycle, `busy` drops, and `cur_ptr`/`cur_cnt`/`cur_idx` give the next address, the remaining count and the next index.
- R8: Restarting with the paused state completes the remaining words. The combined writes and final state equal an uninterrupted run.
- R9: A response with `rsp_parity_err`=1 (and no fault) gives one-cycle `trap`, `trap_parity`=1 and `reg_altered`=1. It causes no write in that step. `cur_ptr`, `cur_cnt` and `cur_idx` keep their values from before that word.
- R10: A response with `rsp_fault`=1 gives `trap` with `trap_parity`=0, no write and unchanged state. `reg_altered` is cleared by each accepted start.
- R11: `start` is ignored while `busy` is high.
- R12: `done`, `paused` and `trap` are never high together, and `wr_en` is never high in a `trap` cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin or resume a load |
| start_ptr | input | AW | Word address of the first image word |
| start_cnt | input | CW | Number of words to move |
| start_idx | input | IW | First register index |
| mode2 | input | 1 | 1: 2-bit locks, full bank; 0: half bank |
| irq | input | 1 | Interrupt request, sampled at each word |
| rd_valid | output | 1 | Read request valid |
| rd_ready | input | 1 | Read request accepted |
| rd_addr | output | AW | Read word address |
| rsp_valid | input | 1 | Read response valid |
| rsp_data | input | DW | Read response word |
| rsp_parity_err | input | 1 | Response parity error |
| rsp_fault | input | 1 | Page missing or protected |
| wr_en | output | 1 | Register write strobe |
| wr_idx | output | IW | Register index written |
| wr_data | output | DW | Register write data |
| busy | output | 1 | Load in progress |
| done | output | 1 | One-cycle completion pulse |
| paused | output | 1 | One-cycle suspend pulse |
| trap | output | 1 | One-cycle trap pulse |
| trap_parity | output | 1 | Last trap was a parity error |
| reg_altered | output | 1 | Registers altered by a run ending in a parity trap |
| cur_ptr | output | AW | Next image word address |
| cur_cnt | output | CW | Words remaining |
| cur_idx | output | IW | Next register index |

## Verification
A start sampled at edge t issues `rd_valid` from t+1. A response sampled at edge u produces `wr_en` and the updated `cur_*` after u. `done`, `paused` or `trap` also appear after u, except for a zero count, where `done` follows the start edge itself. The bench drives inputs and samples outputs at falling edges. It keeps a behavioural queue of expected register writes that is compared on every clock where `wr_en` is high, and it checks the end pulse and saved state in the half cycle after the edge that produced them.

// File: rtl/imglock_pkg.sv
package imglock_pkg;
  typedef enum logic [1:0] {
    LD_IDLE = 2'd0,
    LD_REQ  = 2'd1,
    LD_WAIT = 2'd2
  } ld_state_t;
endpackage

// File: rtl/imglock_wrap.sv
module imglock_wrap #(
  parameter int IW = 7
) (
  input  logic [IW-1:0] raw_idx,
  input  logic          full_bank,
  output logic [IW-1:0] bank_idx
);
  localparam logic [IW-1:0] HALF_MASK = {1'b0, {(IW-1){1'b1}}};
  assign bank_idx = full_bank ? raw_idx : (raw_idx & HALF_MASK);
endmodule

// File: rtl/imglock_step.sv
module imglock_step #(
  parameter int AW = 20,
  parameter int CW = 12,
  parameter int IW = 7
) (
  input  logic [AW-1:0] ptr,
  input  logic [CW-1:0] cnt,
  input  logic [IW-1:0] idx,
  input  logic          full_bank,
  output logic [AW-1:0] nxt_ptr,
  output logic [CW-1:0] nxt_cnt,
  output logic [IW-1:0] nxt_idx,
  output logic          last_word
);
  logic [IW-1:0] inc_idx;
  assign inc_idx   = idx + IW'(1);
  assign nxt_ptr   = ptr + AW'(1);
  assign nxt_cnt   = cnt - CW'(1);
  assign last_word = (cnt == CW'(1));

  imglock_wrap #(.IW(IW)) u_wrap (
    .raw_idx  (inc_idx),
    .full_bank(full_bank),
    .bank_idx (nxt_idx)
  );
endmodule

// File: rtl/imglock_loader.sv
module imglock_loader
  import imglock_pkg::*;
#(
  parameter int AW = 20,
  parameter int CW = 12,
  parameter int IW = 7,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [AW-1:0] start_ptr,
  input  logic [CW-1:0] start_cnt,
  input  logic [IW-1:0] start_idx,
  input  logic          mode2,
  input  logic          irq,
  output logic          rd_valid,
  input  logic          rd_ready,
  output logic [AW-1:0] rd_addr,
  input  logic          rsp_valid,
  input  logic [DW-1:0] rsp_data,
  input  logic          rsp_parity_err,
  input  logic          rsp_fault,
  output logic          wr_en,
  output logic [IW-1:0] wr_idx,
  output logic [DW-1:0] wr_data,
  output logic          busy,
  output logic          done,
  output logic          paused,
  output logic          trap,
  output logic          trap_parity,
  output logic          reg_altered,
  output logic [AW-1:0] cur_ptr,
  output logic [CW-1:0] cur_cnt,
  output logic [IW-1:0] cur_idx
);
  ld_state_t     state;
  logic          mode_q;
  logic [IW-1:0] first_idx;
  logic [AW-1:0] step_ptr;
  logic [CW-1:0] step_cnt;
  logic [IW-1:0] step_idx;
  logic          step_last;

  imglock_wrap #(.IW(IW)) u_first (
    .raw_idx  (start_idx),
    .full_bank(mode2),
    .bank_idx (first_idx)
  );

  imglock_step #(.AW(AW), .CW(CW), .IW(IW)) u_step (
    .ptr      (cur_ptr),
    .cnt      (cur_cnt),
    .idx      (cur_idx),
    .full_bank(mode_q),
    .nxt_ptr  (step_ptr),
    .nxt_cnt  (step_cnt),
    .nxt_idx  (step_idx),
    .last_word(step_last)
  );

  assign rd_valid = (state == LD_REQ);
  assign rd_addr  = cur_ptr;
  assign busy     = (state != LD_IDLE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state       <= LD_IDLE;
      mode_q      <= 1'b0;
      cur_ptr     <= '0;
      cur_cnt     <= '0;
      cur_idx     <= '0;
      wr_en       <= 1'b0;
      wr_idx      <= '0;
      wr_data     <= '0;
      done        <= 1'b0;
      paused      <= 1'b0;
      trap        <= 1'b0;
      trap_parity <= 1'b0;
      reg_altered <= 1'b0;
    end else begin
      wr_en  <= 1'b0;
      done   <= 1'b0;
      paused <= 1'b0;
      trap   <= 1'b0;
      unique case (state)
        LD_IDLE: begin
          if (start) begin
            cur_ptr     <= start_ptr;
            cur_cnt     <= start_cnt;
            cur_idx     <= first_idx;
            mode_q      <= mode2;
            reg_altered <= 1'b0;
            trap_parity <= 1'b0;
            if (start_cnt == '0) done  <= 1'b1;
            else                 state <= LD_REQ;
          end
        end
        LD_REQ: begin
          if (rd_ready) state <= LD_WAIT;
        end
        LD_WAIT: begin
          if (rsp_valid) begin
            if (rsp_fault || rsp_parity_err) begin
              trap        <= 1'b1;
              trap_parity <= !rsp_fault;
              reg_altered <= !rsp_fault;
              state       <= LD_IDLE;
            end else begin
              wr_en   <= 1'b1;
              wr_idx  <= cur_idx;
              wr_data <= rsp_data;
              cur_ptr <= step_ptr;
              cur_cnt <= step_cnt;
              cur_idx <= step_idx;
              if (step_last) begin
                done  <= 1'b1;
                state <= LD_IDLE;
              end else if (irq) begin
                paused <= 1'b1;
                state  <= LD_IDLE;
              end else begin
                state <= LD_REQ;
              end
            end
          end
        end
        default: state <= LD_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/imglock_loader_chk.sv
module imglock_loader_chk #(
  parameter int AW = 20,
  parameter int CW = 12,
  parameter int IW = 7
) (
  input logic          clk,
  input logic          rst_n,
  input logic          rd_valid,
  input logic          rd_ready,
  input logic [AW-1:0] rd_addr,
  input logic          rsp_valid,
  input logic          rsp_parity_err,
  input logic          wr_en,
  input logic          done,
  input logic          paused,
  input logic          trap,
  input logic          trap_parity,
  input logic          reg_altered,
  input logic [CW-1:0] cur_cnt,
  input logic [IW-1:0] cur_idx,
  input logic [AW-1:0] cur_ptr,
  input logic          mode_q
);
  // R6
  rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid && !rd_ready |=> rd_valid && $stable(rd_addr));
  // R12
  end_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({done, paused, trap}));
  // R12
  trap_nowrite_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trap |-> !wr_en);
  // R3
  done_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> cur_cnt == '0);
  // R7
  pause_left_chk: assert property (@(posedge clk) disable iff (!rst_n)
    paused |-> cur_cnt != '0);
  // R4
  half_bank_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !mode_q |-> !cur_idx[IW-1]);
  // R9
  parity_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trap && trap_parity |-> reg_altered);
  // R9
  trap_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trap |-> $stable(cur_ptr) && $stable(cur_cnt) && $stable(cur_idx));
  // R2
  write_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> $past(rsp_valid) && !$past(rsp_parity_err));
endmodule

bind imglock_loader imglock_loader_chk #(.AW(AW), .CW(CW), .IW(IW)) u_chk (.*);

// File: tb/imglock_loader_bench.sv
module imglock_loader_bench;
  localparam int AW = 20, CW = 12, IW = 7, DW = 32;

  logic clk = 1'b0, rst_n = 1'b0;
  logic start = 1'b0, mode2 = 1'b1, irq = 1'b0;
  logic [AW-1:0] start_ptr = '0;
  logic [CW-1:0] start_cnt = '0;
  logic [IW-1:0] start_idx = '0;
  logic rd_valid, rd_ready, rsp_valid = 1'b0, rsp_parity_err = 1'b0, rsp_fault = 1'b0;
  logic [AW-1:0] rd_addr;
  logic [DW-1:0] rsp_data = '0;
  logic wr_en, busy, done, paused, trap, trap_parity, reg_altered;
  logic [IW-1:0] wr_idx, cur_idx;
  logic [DW-1:0] wr_data;
  logic [AW-1:0] cur_ptr;
  logic [CW-1:0] cur_cnt;

  int checks = 0, errors = 0, cyc = 0;
  logic stall_en = 1'b0;
  logic [AW-1:0] bad_par = '1, bad_flt = '1;
  logic [IW+DW-1:0] expq[$];

  always #5 clk = ~clk;

  imglock_loader u_imglock_loader (.*);

  function automatic logic [DW-1:0] img(input logic [AW-1:0] a);
    return {a[11:0], a} ^ 32'h5A3C_96E1;
  endfunction

  assign rd_ready = !stall_en || (cyc % 3 == 0);

  always @(posedge clk) begin
    cyc            <= cyc + 1;
    rsp_valid      <= rd_valid && rd_ready;
    rsp_data       <= img(rd_addr);
    rsp_parity_err <= rd_valid && rd_ready && (rd_addr == bad_par);
    rsp_fault      <= rd_valid && rd_ready && (rd_addr == bad_flt);
  end

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && wr_en) begin
      if (expq.size() == 0) chk(0, "R2 unexpected write", {wr_idx, wr_data}, 0);
      else begin
        logic [IW+DW-1:0] e;
        e = expq.pop_front();
        chk({wr_idx, wr_data} == e, "R2 write idx/data", {wr_idx, wr_data}, e);
      end
    end
    if (cyc > 150000) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=0", cyc);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic expect_run(input logic [AW-1:0] p, input int n, input logic [IW-1:0] i, input bit m);
    logic [IW-1:0] x;
    x = m ? i : (i & {1'b0, {(IW-1){1'b1}}});
    for (int k = 0; k < n; k++) begin
      expq.push_back({x, img(p + AW'(k))});
      x = x + IW'(1);
      if (!m) x[IW-1] = 1'b0;
    end
  endtask

  task automatic run(input logic [AW-1:0] p, input int n, input logic [IW-1:0] i, input bit m);
    start_ptr = p; start_cnt = CW'(n); start_idx = i; mode2 = m; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    while (!(done || paused || trap)) @(negedge clk);
  endtask

  task automatic end_state(input string tag, input logic [AW-1:0] p, input int c, input logic [IW-1:0] i);
    chk(cur_ptr == p, {tag, " ptr"}, cur_ptr, p);
    chk(cur_cnt == CW'(c), {tag, " cnt"}, cur_cnt, c);
    chk(cur_idx == i, {tag, " idx"}, cur_idx, i);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1
    chk({busy, done, paused, trap, trap_parity, reg_altered, rd_valid, wr_en} == 0,
        "R1 reset outputs", {busy, done, paused, trap, rd_valid, wr_en}, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R2 R3 basic run
    expect_run(20'h100, 5, 7'd3, 1'b1);
    run(20'h100, 5, 7'd3, 1'b1);
    chk(done && !busy, "R3 done pulse", done, 1);
    end_state("R3", 20'h105, 0, 7'd8);
    @(negedge clk);
    chk(!done, "R3 done one cycle", done, 0);

    // R4 full-bank wrap with stalls
    stall_en = 1'b1;
    expect_run(20'h180, 4, 7'd126, 1'b1);
    run(20'h180, 4, 7'd126, 1'b1);
    end_state("R4 full wrap", 20'h184, 0, 7'd2);

    // R4 half bank, start index top bit masked
    expect_run(20'h1C0, 3, 7'h7E, 1'b0);
    run(20'h1C0, 3, 7'h7E, 1'b0);
    end_state("R4 half wrap", 20'h1C3, 0, 7'd1);
    stall_en = 1'b0;

    // R5 zero count
    run(20'h2AA, 0, 7'd9, 1'b1);
    chk(done && !rd_valid, "R5 zero count done", done, 1);
    end_state("R5", 20'h2AA, 0, 7'd9);

    // R7 pause then R8 resume
    expect_run(20'h200, 6, 7'd10, 1'b1);
    irq = 1'b1;
    run(20'h200, 6, 7'd10, 1'b1);
    irq = 1'b0;
    chk(paused && !busy, "R7 paused", paused, 1);
    end_state("R7", 20'h201, 5, 7'd11);
    repeat (3) @(negedge clk);
    chk(!rd_valid && expq.size() == 5, "R7 no read after pause", expq.size(), 5);
    run(cur_ptr, int'(cur_cnt), cur_idx, 1'b1);
    chk(done, "R8 resumed done", done, 1);
    end_state("R8", 20'h206, 0, 7'd16);

    // R9 parity trap
    bad_par = 20'h302;
    expect_run(20'h300, 2, 7'd40, 1'b1);
    run(20'h300, 5, 7'd40, 1'b1);
    chk(trap && trap_parity && reg_altered && !wr_en, "R9 parity trap",
        {trap, trap_parity, reg_altered, wr_en}, 4'b1110);
    end_state("R9", 20'h302, 3, 7'd42);
    bad_par = '1;

    // R10 fault trap
    bad_flt = 20'h400;
    run(20'h400, 3, 7'd50, 1'b1);
    chk(trap && !trap_parity && !reg_altered && !wr_en, "R10 fault trap",
        {trap, trap_parity, reg_altered, wr_en}, 4'b1000);
    end_state("R10", 20'h400, 3, 7'd50);
    bad_flt = '1;

    // R11 start ignored while busy
    stall_en = 1'b1;
    expect_run(20'h500, 4, 7'd20, 1'b1);
    start_ptr = 20'h500; start_cnt = 4; start_idx = 7'd20; mode2 = 1'b1; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (2) @(negedge clk);
    start_ptr = 20'h600; start_cnt = 1; start_idx = 7'd0; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    while (!done) @(negedge clk);
    end_state("R11", 20'h504, 0, 7'd24);
    stall_en = 1'b0;

    // R4 overwrite of first registers with count above bank size
    expect_run(20'h800, 130, 7'd0, 1'b1);
    run(20'h800, 130, 7'd0, 1'b1);
    end_state("R4 overwrite", 20'h882, 0, 7'd2);

    @(negedge clk);
    chk(expq.size() == 0, "R2 all writes seen", expq.size(), 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule